// File: doc/BRIEF.md
# NAND Bus Cycle Sequencer

This block turns single register-level accesses from a host into timed 8-bit NAND flash bus cycles. A write to the command port produces one write cycle with the command latch enable asserted. A write to the address port produces one write cycle with the address latch enable asserted. A write to the data port produces a plain data write cycle. A read of the data port produces a read cycle and returns the byte captured from the flash bus.

Every bus cycle has three phases: setup, strobe and hold. Each phase length comes from a 4-bit field of one 32-bit timing word. Reads and writes have separate sets of fields. After the hold phase, an optional ready-wait delays the sampling of the ready/busy pin. The host bus stalls until the cycle finishes. A configuration bit forces chip enable active. A control bit releases chip enable and puts the sequencer back into idle.

Top module: `nand_seq`

## Requirements
- R1: While reset is applied, and right after it, the outputs are all inactive: chip enable high, WE# high, RE# high, CLE and ALE low, dq_oe low. `busy_o` and `nand_ready_o` are low.
- R2: `acc_addr_i` selects the register: 0 data port, 1 address port, 2 command port, 3 control, 4 configuration, 5 status, 6 timing. Accesses to control, configuration, status and timing complete in the cycle they are presented, with `acc_ready_o` high and no bus cycle. Configuration and timing read back what was written. A read of the address or command port also completes at once, returns zero and starts no bus cycle.
- R3: A command-port write drives `wdata[7:0]` on the bus with dq_oe high. CLE is high for the whole setup, strobe and hold span, and ALE stays low.
- R4: An address-port write behaves like R3, with ALE in place of CLE.
- R5: A data-port write has neither CLE nor ALE. WE# is the only strobe, and dq_oe is high across setup, strobe and hold.
- R6: A data-port read uses RE# as the strobe and keeps dq_oe low. The byte on `nand_dq_i` is captured on the clock edge at which RE# returns high. That byte is returned on `acc_rdata_o[7:0]`, with upper bits zero, in the completing cycle.
- R7: Phase lengths come from timing-word fields, where a value n lasts n+1 clocks. Read fields are setup [3:0], hold [7:4] and strobe width [11:8]. Write fields are setup [19:16], hold [23:20] and strobe width [27:24]. The strobe is active only in the width phase.
- R8: The read ready-wait field is [15:12] and the write ready-wait field is [31:28]. A value r adds 2*r clocks after the hold phase, with all strobes, CLE, ALE and dq_oe inactive. One completing cycle follows.
- R9: While idle, the ready flag (`nand_ready_o`, status bit 0, 1 = ready) takes `nand_rb_i` on every clock. During setup, strobe, hold and wait it holds its value. It is resampled on the edge that ends the wait, or ends the hold phase when r is 0.
- R10: Chip enable (`nand_ce_no`) is low exactly while configuration bit 5 is set, starting in the cycle after the write. Configuration reads back only bit 5.
- R11: A port access keeps `acc_ready_o` low until its completing cycle. `busy_o` is high from the cycle after acceptance through the completing cycle. The sequencer is idle in the cycle after that.
- R12: A control write with bit 2 set returns the sequencer to idle and clears the configuration bit, which releases chip enable. A control write with bit 2 clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Host access request, held until acc_ready_o |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 3 | Register select |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data |
| acc_ready_o | output | 1 | Access completes this cycle |
| busy_o | output | 1 | A bus cycle is in progress |
| nand_ready_o | output | 1 | Sampled ready/busy state |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe_o | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rb_i | input | 1 | Ready/busy pin, 1 = ready |

## Verification
Two events share a clock edge, the RE# release and the capture of read data. The bench drives the wanted byte only in the last strobe cycle and garbage in the cycles before and after it, so a capture one edge early or late returns the wrong byte. The ready sample at the end of the wait also coincides with the entry into the completing cycle. The bench flips `nand_rb_i` early in a long cycle and expects the ready flag to stay frozen until exactly that edge. A reference model in the bench counts the phase lengths from the timing word it wrote and compares every strobe and control pin on each clock.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_WAIT, PH_DONE
  } phase_e;

  localparam logic [2:0] RA_DATA = 3'd0;
  localparam logic [2:0] RA_ADDR = 3'd1;
  localparam logic [2:0] RA_CMD  = 3'd2;
  localparam logic [2:0] RA_CTRL = 3'd3;
  localparam logic [2:0] RA_CFG  = 3'd4;
  localparam logic [2:0] RA_STAT = 3'd5;
  localparam logic [2:0] RA_TIME = 3'd6;

  // field slots within one half of the timing word
  localparam int F_SETUP = 0;
  localparam int F_HOLD  = 1;
  localparam int F_WIDTH = 2;
  localparam int F_WAIT  = 3;
endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs #(
  parameter int TW_W          = 32,
  parameter int CFG_CE_BIT    = 5,
  parameter int CTRL_SRST_BIT = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic            ctrl_we_i,
  input  logic            tim_we_i,
  input  logic [TW_W-1:0] wdata_i,
  input  logic            rdy_upd_i,
  input  logic            rb_i,
  output logic            ce_force_o,
  output logic [TW_W-1:0] tim_o,
  output logic            rdy_o,
  output logic            srst_o
);
  assign srst_o = ctrl_we_i && wdata_i[CTRL_SRST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_force_o <= 1'b0;
      tim_o      <= '0;
      rdy_o      <= 1'b0;
    end else begin
      if (srst_o)        ce_force_o <= 1'b0;
      else if (cfg_we_i) ce_force_o <= wdata_i[CFG_CE_BIT];
      if (tim_we_i)      tim_o <= wdata_i;
      if (rdy_upd_i)     rdy_o <= rb_i;
    end
  end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 srst_i,
  input  logic                 start_i,
  input  logic [4*FIELD_W-1:0] tim_i,
  output phase_e               phase_o,
  output logic                 strobe_end_o,
  output logic                 wait_end_o
);
  localparam int HALF_W = 4 * FIELD_W;
  localparam int CNT_W  = FIELD_W + 1;

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [HALF_W-1:0]  tim_q;
  logic               cnt_zero;
  logic [FIELD_W-1:0] wait_f;

  function automatic logic [FIELD_W-1:0] get_fld(input logic [HALF_W-1:0] t, input int idx);
    return t[idx*FIELD_W +: FIELD_W];
  endfunction

  assign cnt_zero     = (cnt_q == '0);
  assign wait_f       = get_fld(tim_q, F_WAIT);
  assign strobe_end_o = (phase_q == PH_STROBE) && cnt_zero;
  assign wait_end_o   = cnt_zero && (((phase_q == PH_HOLD) && (wait_f == '0)) ||
                                     (phase_q == PH_WAIT));
  assign phase_o      = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      tim_q   <= '0;
    end else if (srst_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SETUP;
          tim_q   <= tim_i;
          cnt_q   <= CNT_W'(get_fld(tim_i, F_SETUP));
        end
        PH_SETUP: if (cnt_zero) begin
          phase_q <= PH_STROBE;
          cnt_q   <= CNT_W'(get_fld(tim_q, F_WIDTH));
        end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE: if (cnt_zero) begin
          phase_q <= PH_HOLD;
          cnt_q   <= CNT_W'(get_fld(tim_q, F_HOLD));
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (cnt_zero) begin
          if (wait_f == '0) phase_q <= PH_DONE;
          else begin
            phase_q <= PH_WAIT;
            cnt_q   <= {wait_f, 1'b0} - CNT_W'(1);
          end
        end else cnt_q <= cnt_q - 1'b1;
        PH_WAIT: if (cnt_zero) phase_q <= PH_DONE;
                 else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  p_setup_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SETUP && !cnt_zero && !srst_i) |=> phase_q == PH_SETUP);
  p_done_once_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DONE) |=> phase_q == PH_IDLE);
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int DQ_W    = 8,
  parameter int FIELD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_we_i,
  input  logic [2:0]        acc_addr_i,
  input  logic [8*FIELD_W-1:0] acc_wdata_i,
  output logic [8*FIELD_W-1:0] acc_rdata_o,
  output logic              acc_ready_o,
  output logic              busy_o,
  output logic              nand_ready_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [DQ_W-1:0]   nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [DQ_W-1:0]   nand_dq_i,
  input  logic              nand_rb_i
);
  localparam int TW_W   = 8 * FIELD_W;
  localparam int HALF_W = 4 * FIELD_W;
  localparam int CE_BIT = 5;

  phase_e            phase;
  logic              port_op, start, active, strobe_end, wait_end;
  logic              cfg_we, ctrl_we, tim_we, srst, ce_force, rdy;
  logic [TW_W-1:0]   tim;
  logic [HALF_W-1:0] tim_sel;
  logic              op_rd_q, op_cle_q, op_ale_q;
  logic [DQ_W-1:0]   byte_q, rd_q;

  assign port_op = acc_valid_i && ((acc_addr_i == RA_DATA) ||
                   (acc_we_i && (acc_addr_i == RA_ADDR || acc_addr_i == RA_CMD)));
  assign start   = port_op && (phase == PH_IDLE);
  assign cfg_we  = acc_valid_i && acc_we_i && (acc_addr_i == RA_CFG);
  assign ctrl_we = acc_valid_i && acc_we_i && (acc_addr_i == RA_CTRL);
  assign tim_we  = acc_valid_i && acc_we_i && (acc_addr_i == RA_TIME);
  assign tim_sel = acc_we_i ? tim[TW_W-1:HALF_W] : tim[HALF_W-1:0];

  nand_seq_regs #(.TW_W(TW_W), .CFG_CE_BIT(CE_BIT), .CTRL_SRST_BIT(2)) u_regs (
    .clk_i, .rst_ni,
    .cfg_we_i(cfg_we), .ctrl_we_i(ctrl_we), .tim_we_i(tim_we),
    .wdata_i(acc_wdata_i),
    .rdy_upd_i((phase == PH_IDLE && !start) || wait_end || phase == PH_DONE),
    .rb_i(nand_rb_i),
    .ce_force_o(ce_force), .tim_o(tim), .rdy_o(rdy), .srst_o(srst)
  );

  nand_seq_fsm #(.FIELD_W(FIELD_W)) u_fsm (
    .clk_i, .rst_ni, .srst_i(srst), .start_i(start), .tim_i(tim_sel),
    .phase_o(phase), .strobe_end_o(strobe_end), .wait_end_o(wait_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_rd_q  <= 1'b0;
      op_cle_q <= 1'b0;
      op_ale_q <= 1'b0;
      byte_q   <= '0;
      rd_q     <= '0;
    end else begin
      if (start) begin
        op_rd_q  <= !acc_we_i;
        op_cle_q <= (acc_addr_i == RA_CMD);
        op_ale_q <= (acc_addr_i == RA_ADDR);
        byte_q   <= acc_wdata_i[DQ_W-1:0];
      end
      if (strobe_end && op_rd_q) rd_q <= nand_dq_i;
    end
  end

  assign active       = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign nand_cle_o   = active && op_cle_q;
  assign nand_ale_o   = active && op_ale_q;
  assign nand_we_no   = !((phase == PH_STROBE) && !op_rd_q);
  assign nand_re_no   = !((phase == PH_STROBE) && op_rd_q);
  assign nand_dq_oe_o = active && !op_rd_q;
  assign nand_dq_o    = byte_q;
  assign nand_ce_no   = !ce_force;
  assign busy_o       = (phase != PH_IDLE);
  assign nand_ready_o = rdy;
  assign acc_ready_o  = !port_op || (phase == PH_DONE);

  always_comb begin
    acc_rdata_o = '0;
    case (acc_addr_i)
      RA_DATA: acc_rdata_o = TW_W'(rd_q);
      RA_CFG:  acc_rdata_o[CE_BIT] = ce_force;
      RA_STAT: acc_rdata_o[0] = rdy;
      RA_TIME: acc_rdata_o = tim;
      default: acc_rdata_o = '0;
    endcase
  end

  logic mid;
  assign mid = active || (phase == PH_WAIT);

  p_one_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));
  p_cle_ale_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));
  p_rdy_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid && $past(mid)) |-> $stable(nand_ready_o));
  p_capture_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || srst)
    (strobe_end && op_rd_q) |=> nand_re_no);
  p_read_no_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o);
endmodule

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_valid = 1'b0, acc_we = 1'b0;
  logic [2:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_ready, busy, nrdy, ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i = '0;
  logic        rb = 1'b1;

  int          n_cmp = 0, n_bad = 0;
  logic        exp_rdy = 1'b0, exp_ce = 1'b0;
  logic [31:0] exp_tim = '0;

  always #10 clk = ~clk;

  nand_seq u_nand_seq (
    .clk_i(clk), .rst_ni, .acc_valid_i(acc_valid), .acc_we_i(acc_we),
    .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata),
    .acc_ready_o(acc_ready), .busy_o(busy), .nand_ready_o(nrdy),
    .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n),
    .nand_re_no(re_n), .nand_dq_o(dq_o), .nand_dq_oe_o(dq_oe),
    .nand_dq_i(dq_i), .nand_rb_i(rb)
  );

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input bit upd);
    @(posedge clk);
    if (upd && rst_ni) exp_rdy = rb;
    @(negedge clk);
  endtask

  task automatic check_idle(input string tag);
    cmp({tag, " busy"}, busy, 0);
    cmp({tag, " cle"}, cle, 0);
    cmp({tag, " ale"}, ale, 0);
    cmp({tag, " we_n"}, we_n, 1);
    cmp({tag, " re_n"}, re_n, 1);
    cmp({tag, " oe"}, dq_oe, 0);
    cmp("R10 ce_n", ce_n, !exp_ce);
    cmp("R9 ready flag", nrdy, exp_rdy);
  endtask

  task automatic reg_acc(input bit we, input logic [2:0] a, input logic [31:0] d,
                         output logic [31:0] rd);
    acc_valid = 1; acc_we = we; acc_addr = a; acc_wdata = d;
    #1;
    cmp("R2 immediate ready", acc_ready, 1);
    rd = acc_rdata;
    @(negedge clk) ;
    #0;
    // back up: use tick semantics from the preceding negedge
  endtask

  task automatic reg_op(input bit we, input logic [2:0] a, input logic [31:0] d,
                        output logic [31:0] rd);
    acc_valid = 1; acc_we = we; acc_addr = a; acc_wdata = d;
    #1;
    cmp("R2 immediate ready", acc_ready, 1);
    rd = acc_rdata;
    tick(1);
    acc_valid = 0;
    if (we && a == 3'd4) exp_ce = d[5];
    if (we && a == 3'd3 && d[2]) exp_ce = 0;
    if (we && a == 3'd6) exp_tim = d;
    #1;
    check_idle("R2 no bus cycle");
  endtask

  task automatic port(input bit we, input logic [2:0] a, input logic [7:0] b, input bit tog);
    int base, s, w, h, r, t;
    base = we ? 16 : 0;
    s = int'(exp_tim[base +: 4]) + 1;
    h = int'(exp_tim[base+4 +: 4]) + 1;
    w = int'(exp_tim[base+8 +: 4]) + 1;
    r = int'(exp_tim[base+12 +: 4]);
    t = s + w + h + 2 * r;
    acc_valid = 1; acc_we = we; acc_addr = a; acc_wdata = {24'hA5A5A5, b};
    dq_i = ~b;
    #1;
    cmp("R11 stall on accept", acc_ready, 0);
    cmp("R11 busy before accept", busy, 0);
    tick(0);
    for (int j = 1; j <= t + 1; j++) begin
      bit strb, act, done, wt;
      strb = (j > s) && (j <= s + w);
      act  = (j <= s + w + h);
      wt   = (j > s + w + h) && (j <= t);
      done = (j == t + 1);
      #1;
      cmp(wt ? "R8 busy in wait" : "R11 busy", busy, 1);
      cmp(wt ? "R8 cle quiet" : "R3 cle", cle, act && a == 3'd2);
      cmp(wt ? "R8 ale quiet" : "R4 ale", ale, act && a == 3'd1);
      cmp("R7 we_n strobe", we_n, !(strb && we));
      cmp("R7 re_n strobe", re_n, !(strb && !we));
      cmp("R5 dq_oe", dq_oe, act && we);
      if (act && we) cmp("R3 dq_o byte", dq_o, b);
      cmp("R11 ready only at end", acc_ready, done);
      cmp("R9 ready flag", nrdy, exp_rdy);
      cmp("R10 ce_n", ce_n, !exp_ce);
      if (done && !we) cmp("R6 read byte", acc_rdata, {24'h0, b});
      if (!we) dq_i = (j == s + w) ? b : (~b ^ 8'(j));
      if (tog && j == 2) rb = ~rb;
      tick(j >= t);
    end
    acc_valid = 0;
    #1;
    check_idle("R11 back to idle");
  endtask

  function automatic logic [31:0] mk(input int rs, rh, rw, rr, ws, wh, ww, wr);
    return {4'(wr), 4'(ww), 4'(wh), 4'(ws), 4'(rr), 4'(rw), 4'(rh), 4'(rs)};
  endfunction

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    @(negedge clk); @(negedge clk);
    #1;
    check_idle("R1 in reset");
    rst_ni = 1;
    #1;
    check_idle("R1 after reset");
    tick(1);
    #1;
    check_idle("R1 idle");

    reg_op(1, 3'd6, 32'h0, rd);
    reg_op(0, 3'd6, 32'h0, rd);
    cmp("R2 timing readback", rd, 32'h0);
    reg_op(1, 3'd4, 32'h0000_00FF, rd);
    reg_op(0, 3'd4, 32'h0, rd);
    cmp("R10 cfg readback bit5 only", rd, 32'h20);

    port(1, 3'd2, 8'h70, 0);
    port(1, 3'd1, 8'h00, 0);
    port(0, 3'd0, 8'h3C, 0);

    reg_op(1, 3'd6, mk(2, 1, 3, 1, 1, 2, 0, 2), rd);
    reg_op(0, 3'd6, 32'h0, rd);
    cmp("R2 timing readback", rd, mk(2, 1, 3, 1, 1, 2, 0, 2));
    port(1, 3'd2, 8'h90, 0);
    port(1, 3'd1, 8'h5A, 0);
    port(1, 3'd0, 8'hC3, 0);
    port(0, 3'd0, 8'h96, 0);

    rb = 0;
    tick(1);
    #1;
    cmp("R9 follows rb when idle", nrdy, 0);
    reg_op(0, 3'd5, 32'h0, rd);
    cmp("R9 status bit0", rd, 32'h0);
    port(0, 3'd0, 8'h4E, 1);
    cmp("R9 resampled at wait end", nrdy, 1);
    reg_op(0, 3'd5, 32'h0, rd);
    cmp("R9 status bit0 ready", rd, 32'h1);

    reg_op(0, 3'd1, 32'h0, rd);
    cmp("R2 address port read is zero", rd, 32'h0);

    reg_op(1, 3'd6, 32'hFFFF_FFFF, rd);
    port(1, 3'd0, 8'hE7, 0);
    port(0, 3'd0, 8'h18, 0);

    reg_op(1, 3'd3, 32'h3, rd);
    cmp("R12 bit2 clear keeps ce", ce_n, 0);
    reg_op(0, 3'd4, 32'h0, rd);
    cmp("R12 cfg unchanged", rd, 32'h20);
    reg_op(1, 3'd3, 32'h4, rd);
    cmp("R12 soft reset releases ce", ce_n, 1);
    reg_op(0, 3'd4, 32'h0, rd);
    cmp("R12 cfg cleared", rd, 32'h0);
    port(1, 3'd2, 8'hFF, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule